// File: doc/BRIEF.md
# Synchronous BCD Decade Counter

This block is a single decimal digit counter held in four D flip-flops that share one clock. With counting enabled it advances one step per clock through the ten decimal codes and then returns to zero. Its next state comes from XOR-form equations for each bit. Because of that, the six codes above nine are not left as don't-cares. Each of them has a fixed successor, and the counter is back in the decimal range after at most two counting edges.

The digit can be cleared to zero at a clock edge or loaded with any 4-bit code. Loading lets a system start from a preset digit, and lets a test place the counter in an unused code on purpose. A carry output shows the enabled step out of nine. A flag marks any code that is not a legal decimal digit.

The asynchronous active-low reset forces zero at once. The counter leaves reset only after a two-stage synchronizer inside the block has seen the clock.

Top module: `bcd_decade_counter`

## Requirements
- R1: While `rst_n` is low, `q_o` is 0000 at once, without waiting for a clock edge, and `invalid_o` and `carry_o` are 0.
- R2: When `cnt_en_i` is 1 and neither clear nor load is requested, a state from 0000 to 1000 goes to that value plus one at the next clock edge.
- R3: When counting from 1001, the next state is 0000.
- R4: When `cnt_en_i`, `clr_i` and `load_i` are all 0, `q_o` keeps its value across the clock edge.
- R5: `clr_i` = 1 sets `q_o` to 0000 at the next clock edge, whatever `load_i` and `cnt_en_i` are.
- R6: `load_i` = 1 with `clr_i` = 0 copies `load_val_i` into `q_o` at the next clock edge, for any of the 16 codes, whatever `cnt_en_i` is.
- R7: `carry_o` is 1 exactly when `q_o` is 1001 and `cnt_en_i` is 1.
- R8: `invalid_o` is 1 exactly for the codes 1010 to 1111, where bit 3 of `q_o` weighs 8 and bit 0 weighs 1.
- R9: Counting from an unused code follows 1010→1011→0110, 1100→1101→0100 and 1110→1111→0010. Every unused code therefore reaches a legal digit within two counting edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all state bits |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| clr_i | input | 1 | Synchronous clear to zero; highest priority |
| cnt_en_i | input | 1 | Count enable |
| load_i | input | 1 | Synchronous load of `load_val_i`; above count enable |
| load_val_i | input | 4 | Code to load |
| q_o | output | 4 | Current state, bit 3 = weight 8 |
| carry_o | output | 1 | Terminal-count carry (state nine and enabled) |
| invalid_o | output | 1 | State is not a decimal digit |

## Verification
The assertions check on every cycle the properties that can be stated step by step:
- the increment, the wrap from nine, hold, clear priority and load;
- that a raised carry is always followed by zero;
- that the invalid flag never appears on a legal digit;
- that an odd unused code always leaves the unused range at the next count, while an even one moves to its odd neighbour.

The bench scenarios are needed for the rest: the complete recovery chains for each unused pair, the immediate effect of the asynchronous reset between edges, the synchronized reset release, and the flag's value for each of the sixteen loaded codes.

// File: rtl/bcd_pkg.sv
`timescale 1ns/1ps
package bcd_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_code_t;
  localparam bcd_code_t BCD_ZERO = bcd_code_t'(0);
  localparam bcd_code_t BCD_NINE = bcd_code_t'(9);

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_STEP  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } bcd_op_t;
endpackage

// File: rtl/bcd_rst_sync.sv
`timescale 1ns/1ps
module bcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = shreg[STAGES-1];
endmodule

// File: rtl/bcd_next_logic.sv
`timescale 1ns/1ps
module bcd_next_logic
  import bcd_pkg::*;
(
  input  bcd_code_t cur,
  output bcd_code_t nxt
);
  logic b1, b2, b4, b8;

  assign b1 = cur[0];
  assign b2 = cur[1];
  assign b4 = cur[2];
  assign b8 = cur[3];

  // Per-bit toggle equations; the unused codes get fixed successors.
  assign nxt[0] = ~b1;
  assign nxt[1] = b2 ^ (b1 & ~b8);
  assign nxt[2] = b4 ^ (b1 & b2);
  assign nxt[3] = b8 ^ ((b1 & b8) | (b1 & b2 & b4));
endmodule

// File: rtl/bcd_state_reg.sv
`timescale 1ns/1ps
module bcd_state_reg
  import bcd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  bcd_op_t   op,
  input  bcd_code_t load_val,
  input  bcd_code_t step_val,
  output bcd_code_t q
);
  bcd_code_t q_d;
  logic      q_ce;

  always_comb begin
    q_ce = (op != OP_HOLD);
    case (op)
      OP_CLEAR: q_d = BCD_ZERO;
      OP_LOAD:  q_d = load_val;
      OP_STEP:  q_d = step_val;
      default:  q_d = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= BCD_ZERO;
    else if (q_ce) q <= q_d;
  end
endmodule

// File: rtl/bcd_status.sv
`timescale 1ns/1ps
module bcd_status
  import bcd_pkg::*;
(
  input  bcd_code_t cur,
  input  logic      cnt_en,
  output logic      carry,
  output logic      invalid
);
  assign invalid = cur[3] & (cur[2] | cur[1]);
  assign carry   = cnt_en & (cur == BCD_NINE);
endmodule

// File: rtl/bcd_decade_counter.sv
`timescale 1ns/1ps
module bcd_decade_counter
  import bcd_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                cnt_en_i,
  input  logic                load_i,
  input  logic [DIGIT_W-1:0]  load_val_i,
  output logic [DIGIT_W-1:0]  q_o,
  output logic                carry_o,
  output logic                invalid_o
);
  logic      rst_core_n;
  bcd_op_t   op;
  bcd_code_t state_q;
  bcd_code_t step_val;

  bcd_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  // Clear beats load, load beats counting.
  always_comb begin
    if (clr_i)         op = OP_CLEAR;
    else if (load_i)   op = OP_LOAD;
    else if (cnt_en_i) op = OP_STEP;
    else               op = OP_HOLD;
  end

  bcd_next_logic u_next (
    .cur (state_q),
    .nxt (step_val)
  );

  bcd_state_reg u_state (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .op       (op),
    .load_val (load_val_i),
    .step_val (step_val),
    .q        (state_q)
  );

  bcd_status u_status (
    .cur     (state_q),
    .cnt_en  (cnt_en_i),
    .carry   (carry_o),
    .invalid (invalid_o)
  );

  assign q_o = state_q;
endmodule

// File: rtl/bcd_decade_counter_chk.sv
`timescale 1ns/1ps
module bcd_decade_counter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr_i,
  input logic       cnt_en_i,
  input logic       load_i,
  input logic [3:0] load_val_i,
  input logic [3:0] q_o,
  input logic       carry_o,
  input logic       invalid_o
);
  logic plain_step;
  assign plain_step = cnt_en_i & ~clr_i & ~load_i;

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_step && q_o < 4'd9) |=> (q_o == $past(q_o) + 4'd1));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_step && q_o == 4'd9) |=> (q_o == 4'd0));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en_i && !clr_i && !load_i) |=> $stable(q_o));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (q_o == 4'd0));

  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clr_i) |=> (q_o == $past(load_val_i)));

  assert_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_o && !clr_i && !load_i) |=> (q_o == 4'd0));

  assert_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_o |-> (q_o >= 4'd10));

  assert_recover_odd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_step && invalid_o && q_o[0]) |=> !invalid_o);

  assert_recover_even_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_step && invalid_o && !q_o[0]) |=> (q_o == $past(q_o) + 4'd1));
endmodule

bind bcd_decade_counter bcd_decade_counter_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .clr_i      (clr_i),
  .cnt_en_i   (cnt_en_i),
  .load_i     (load_i),
  .load_val_i (load_val_i),
  .q_o        (q_o),
  .carry_o    (carry_o),
  .invalid_o  (invalid_o)
);

// File: tb/bcd_decade_counter_tb.sv
`timescale 1ns/1ps
module bcd_decade_counter_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       clr_i, cnt_en_i, load_i;
  logic [3:0] load_val_i;
  logic [3:0] q_o;
  logic       carry_o, invalid_o;

  int nchk = 0;
  int nfail = 0;
  logic [3:0] mq;

  typedef struct {
    logic [3:0] q;
    string      tag;
  } exp_t;
  exp_t sbq[$];
  exp_t item;

  always #2 clk = ~clk;

  bcd_decade_counter u_dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .cnt_en_i(cnt_en_i),
    .load_i(load_i), .load_val_i(load_val_i), .q_o(q_o),
    .carry_o(carry_o), .invalid_o(invalid_o)
  );

  function automatic logic [3:0] ref_next(logic [3:0] s, logic c, logic e,
                                          logic l, logic [3:0] v);
    if (c)  return 4'd0;
    if (l)  return v;
    if (!e) return s;
    case (s)
      4'd9:  return 4'd0;
      4'd10: return 4'd11;
      4'd11: return 4'd6;
      4'd12: return 4'd13;
      4'd13: return 4'd4;
      4'd14: return 4'd15;
      4'd15: return 4'd2;
      default: return s + 4'd1;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected state.
  task automatic apply(input logic c, input logic e, input logic l,
                       input logic [3:0] v, input string tag);
    exp_t it;
    @(negedge clk);
    clr_i = c; cnt_en_i = e; load_i = l; load_val_i = v;
    #1;
    check("R7 carry", int'(carry_o), int'((mq == 4'd9) && e));
    mq = ref_next(mq, c, e, l, v);
    it.q = mq; it.tag = tag;
    sbq.push_back(it);
  endtask

  // Monitor: compares the state after each edge with the queued item.
  always @(posedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      item = sbq.pop_front();
      check({item.tag, " state"}, int'(q_o), int'(item.q));
      check("R8 invalid", int'(invalid_o), int'(item.q >= 4'd10));
    end
  end

  task automatic idle_reset_release();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr_i = 0; cnt_en_i = 0; load_i = 0; load_val_i = '0;
    mq = 4'd0;
    repeat (3) @(negedge clk);
    check("R1 reset state", int'(q_o), 0);
    check("R1 reset invalid", int'(invalid_o), 0);
    check("R1 reset carry", int'(carry_o), 0);
    idle_reset_release();

    // R2, R3: two full decades
    for (int i = 0; i < 20; i++) apply(0, 1, 0, 4'd0, "R2/R3 count");

    // R4: hold at several values, including nine
    for (int i = 0; i < 3; i++) apply(0, 0, 0, 4'd0, "R4 hold");
    apply(0, 0, 1, 4'd9, "R6 load");
    for (int i = 0; i < 3; i++) apply(0, 0, 0, 4'd0, "R4 hold at nine");
    apply(0, 1, 0, 4'd0, "R3 wrap");

    // R8: every code loaded, then held
    for (int v = 0; v < 16; v++) begin
      apply(0, 0, 1, 4'(v), "R6 load code");
      apply(0, 0, 0, 4'd0, "R4 hold loaded");
    end

    // R9: recovery chains from each unused code
    for (int v = 10; v < 16; v++) begin
      apply(0, 0, 1, 4'(v), "R6 load unused");
      apply(0, 1, 0, 4'd0, "R9 recover step1");
      apply(0, 1, 0, 4'd0, "R9 recover step2");
    end

    // R5: clear wins over load and enable
    apply(0, 0, 1, 4'd7, "R6 load");
    apply(1, 1, 1, 4'd5, "R5 clear priority");
    apply(0, 1, 0, 4'd0, "R2 count after clear");
    // R6: load wins over enable
    apply(0, 1, 1, 4'd3, "R6 load over enable");
    apply(0, 1, 1, 4'd12, "R6 load unused over enable");
    apply(1, 0, 0, 4'd0, "R5 clear alone");

    // R1: asynchronous reset between edges
    apply(0, 0, 1, 4'd8, "R6 load");
    apply(0, 1, 0, 4'd0, "R2 count");
    @(negedge clk);
    cnt_en_i = 0; load_i = 0; clr_i = 0;
    rst_n = 1'b0;
    #0.5;
    check("R1 async reset", int'(q_o), 0);
    mq = 4'd0;
    repeat (2) @(negedge clk);
    check("R1 held in reset", int'(q_o), 0);
    idle_reset_release();
    apply(0, 1, 0, 4'd0, "R2 count after reset");
    apply(0, 1, 0, 4'd0, "R2 count after reset");

    @(posedge clk);
    #2;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule